// File: doc/BRIEF.md
# BCD/Binary Time-of-Day Calendar Counter

This block holds a wall-clock time and calendar date as eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, year within the century, and century. It advances by one second each time a one-second tick arrives. A single global mode input decides whether every field holds packed BCD or plain binary. A second global input selects a 24-hour clock or a 12-hour clock that keeps an AM/PM flag in the hour byte. Fields are never converted, so a host that changes either mode rewrites the time itself.

The host loads the time while a hold input is high. Holding also stops all advancing. Every field can be read back at any time through a select-driven read port, and the byte returned is the one that was stored. Before each advance, a busy flag warns the host that the fields are about to change for a fixed number of clock cycles. A one-cycle done strobe follows the advance, so the interrupt logic can report that an update has ended.

Top module: `todCalendar`

## Requirements
- R1: After reset, seconds, minutes, hours, year and century read 0, day of week, day of month and month read 1, and both `updBusy` and `updDone` are 0.
- R2: Field select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. A write while `setHold` is 1 stores `wrData` into the selected field, and `rdData` then returns those exact bits.
- R3: A write while `setHold` is 0 has no effect on any field.
- R4: With `binMode` 0 each field is packed BCD (tens in bits 7:4, units in bits 3:0). With `binMode` 1 it is binary. Changing `binMode` or `hr24` leaves the stored bytes untouched.
- R5: Seconds and minutes count 0 to 59. The wrap from 59 to 0 advances the next field.
- R6: With `hr24` 1, hours count 0 to 23, and the wrap from 23 to 0 advances the day.
- R7: With `hr24` 0, hour bit 7 is 1 for PM and bits 6:0 hold 1 to 12. 11 AM becomes 12 PM, 11 PM becomes 12 AM and advances the day, and 12 becomes 1 in the same half of the day without advancing the day.
- R8: Day of week counts 1 (Sunday) to 7 and wraps from 7 to 1 on each day advance.
- R9: Day of month wraps to 1 after 31, 30, 28 or 29 days, depending on the month. February has 29 days when the year value is a multiple of 4. The wrap advances the month, and month 12 wraps to 1 and advances the year.
- R10: Year 99 wraps to 0 and advances the century. Century 99 wraps to 0.
- R11: A tick seen while idle with `setHold` 0 raises `updBusy` from the next cycle for exactly LEAD cycles. The fields change at the end of that window. `updDone` is high for exactly the one cycle after `updBusy` falls, and the new values are readable in that cycle.
- R12: A tick seen with `setHold` 1 starts no window and changes nothing. If `setHold` is 1 in the last busy cycle, the advance is dropped and no `updDone` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle once-per-second advance request |
| setHold | input | 1 | Stops advancing and enables host writes |
| binMode | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24 | input | 1 | 1 = 24-hour clock, 0 = 12-hour clock with PM flag |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 3 | Field written |
| wrData | input | 8 | Byte written |
| rdSel | input | 3 | Field read |
| rdData | output | 8 | Selected field, combinational |
| updBusy | output | 1 | Update about to happen or happening |
| updDone | output | 1 | One-cycle pulse after an advance |

## Verification
Two things can land in the same cycle: the host raising `setHold` and the advance itself. The bench provokes this by sending a tick and then raising `setHold` exactly in the last busy cycle. It then requires that `updDone` stays low and that every field reads back as it was before the tick. Separately, the bench sweeps every hour in both clock formats and both encodings, and the last day of every month in a leap year and a non-leap year. It compares each result with a binary reference clock kept in the bench and re-encoded arithmetically.

// File: rtl/todPkg.sv
package todPkg;
  localparam int FIELD_W = 8;
  localparam int NFIELD  = 8;
  localparam int SEL_W   = $clog2(NFIELD);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef struct packed {
    logic step;   // apply one-second advance this cycle
    logic load;   // host write accepted this cycle
  } todStrobe_t;

  // decode a stored byte to a binary number
  function automatic logic [7:0] toBin(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    tens = {4'b0, v[7:4]};
    return bin ? v : (tens * 8'd10 + {4'b0, v[3:0]});
  endfunction

  // encode a binary number (0..99) into the stored form
  function automatic logic [7:0] fromBin(input logic [7:0] n, input logic bin);
    logic [7:0] t, u;
    t = n / 8'd10;
    u = n % 8'd10;
    return bin ? n : {t[3:0], u[3:0]};
  endfunction

  // {carry, next} for a field counting lo..hi
  function automatic logic [8:0] bumpField(input logic [7:0] v, input logic [7:0] lo,
                                           input logic [7:0] hi, input logic bin);
    logic [7:0] n;
    n = toBin(v, bin);
    if (n >= hi) return {1'b1, fromBin(lo, bin)};
    return {1'b0, fromBin(n + 8'd1, bin)};
  endfunction

  function automatic logic [8:0] stepHour(input logic [7:0] v, input logic bin, input logic h24);
    logic [7:0] h, e;
    logic pm;
    if (h24) return bumpField(v, 8'd0, 8'd23, bin);
    pm = v[7];
    h  = toBin({1'b0, v[6:0]}, bin);
    if (h == 8'd12) begin
      e = fromBin(8'd1, bin);
      return {1'b0, pm, e[6:0]};
    end
    if (h == 8'd11) begin
      e = fromBin(8'd12, bin);
      return {pm, ~pm, e[6:0]};
    end
    e = fromBin(h + 8'd1, bin);
    return {1'b0, pm, e[6:0]};
  endfunction

  function automatic logic [7:0] daysIn(input logic [7:0] mon, input logic [7:0] yr);
    if (mon == 8'd2) return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
    if (mon == 8'd4 || mon == 8'd6 || mon == 8'd9 || mon == 8'd11) return 8'd30;
    return 8'd31;
  endfunction
endpackage

// File: rtl/todCtrl.sv
module todCtrl
  import todPkg::*;
#(
  parameter int LEAD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       setHold,
  input  logic       wrEn,
  output todStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = (LEAD > 1) ? $clog2(LEAD) : 1;

  logic [CNT_W-1:0] cnt;

  assign strobe.step = busy && (cnt == '0) && !setHold;
  assign strobe.load = wrEn && setHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= strobe.step;
      if (!busy) begin
        if (tick && !setHold) begin
          busy <= 1'b1;
          cnt  <= CNT_W'(LEAD - 1);
        end
      end else if (cnt == '0) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/todData.sv
module todData
  import todPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  todStrobe_t         strobe,
  input  logic               binMode,
  input  logic               hr24,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [FIELD_W-1:0] rdData
);
  logic [FIELD_W-1:0] fld [NFIELD];
  logic [FIELD_W-1:0] nxt [NFIELD];
  logic [8:0] secN, minN, hrN, dowN, domN, monN, yrN, cenN;
  logic cSec, cMin, cHour, cDay, cMon, cYear;

  always_comb begin
    secN = bumpField(fld[F_SEC], 8'd0, 8'd59, binMode);
    minN = bumpField(fld[F_MIN], 8'd0, 8'd59, binMode);
    hrN  = stepHour(fld[F_HOUR], binMode, hr24);
    dowN = bumpField(fld[F_DOW], 8'd1, 8'd7, binMode);
    domN = bumpField(fld[F_DOM], 8'd1,
                     daysIn(toBin(fld[F_MON], binMode), toBin(fld[F_YEAR], binMode)), binMode);
    monN = bumpField(fld[F_MON], 8'd1, 8'd12, binMode);
    yrN  = bumpField(fld[F_YEAR], 8'd0, 8'd99, binMode);
    cenN = bumpField(fld[F_CENT], 8'd0, 8'd99, binMode);

    cSec  = secN[8];
    cMin  = cSec && minN[8];
    cHour = cMin && hrN[8];
    cDay  = cHour && domN[8];
    cMon  = cDay && monN[8];
    cYear = cMon && yrN[8];

    nxt[F_SEC]  = secN[7:0];
    nxt[F_MIN]  = cSec  ? minN[7:0] : fld[F_MIN];
    nxt[F_HOUR] = cMin  ? hrN[7:0]  : fld[F_HOUR];
    nxt[F_DOW]  = cHour ? dowN[7:0] : fld[F_DOW];
    nxt[F_DOM]  = cHour ? domN[7:0] : fld[F_DOM];
    nxt[F_MON]  = cDay  ? monN[7:0] : fld[F_MON];
    nxt[F_YEAR] = cMon  ? yrN[7:0]  : fld[F_YEAR];
    nxt[F_CENT] = cYear ? cenN[7:0] : fld[F_CENT];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : gFld
    localparam logic [FIELD_W-1:0] RST_VAL =
      (i == F_DOW || i == F_DOM || i == F_MON) ? FIELD_W'(1) : '0;
    always_ff @(posedge clk) begin
      if (!rstN)                                   fld[i] <= RST_VAL;
      else if (strobe.load && wrSel == SEL_W'(i))  fld[i] <= wrData;
      else if (strobe.step)                        fld[i] <= nxt[i];
    end
  end

  assign rdData = fld[rdSel];
endmodule

// File: rtl/todCalendar.sv
module todCalendar
  import todPkg::*;
#(
  parameter int LEAD = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               setHold,
  input  logic               binMode,
  input  logic               hr24,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [FIELD_W-1:0] rdData,
  output logic               updBusy,
  output logic               updDone
);
  todStrobe_t strobe;

  todCtrl #(.LEAD(LEAD)) ctrlI (
    .clk(clk), .rstN(rstN), .tick(tick), .setHold(setHold), .wrEn(wrEn),
    .strobe(strobe), .busy(updBusy), .done(updDone)
  );

  todData dataI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .binMode(binMode), .hr24(hr24),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData)
  );
endmodule

// File: rtl/todCalendar_chk.sv
module todCalendar_chk #(
  parameter int LEAD = 4
) (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic setHold,
  input logic updBusy,
  input logic updDone
);
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)        runLen <= '0;
    else if (updBusy) runLen <= runLen + 16'd1;
    else              runLen <= '0;
  end

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !setHold && !updBusy) |=> updBusy);

  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updBusy) |-> (int'(runLen) == LEAD));

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> ($past(updBusy) && !updBusy));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |=> !updDone);

  // R12
  hold_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updBusy) |-> !$past(setHold));

  // R12
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> !$past(setHold));
endmodule

bind todCalendar todCalendar_chk #(.LEAD(LEAD)) chkI (
  .clk(clk), .rstN(rstN), .tick(tick), .setHold(setHold),
  .updBusy(updBusy), .updDone(updDone)
);

// File: tb/todCalendar_test.sv
module todCalendar_test;
  localparam int LEAD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, setHold = 1'b0, binMode = 1'b0, hr24 = 1'b1, wrEn = 1'b0;
  logic [2:0] wrSel = '0, rdSel = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic updBusy, updDone;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  // binary reference clock, hour kept 0..23
  int ms, mm, mh, mdw, mdm, mmo, my, mc;

  always #10 clk = ~clk;

  todCalendar #(.LEAD(LEAD)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .setHold(setHold), .binMode(binMode),
    .hr24(hr24), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .updBusy(updBusy), .updDone(updDone)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int enc(int n, bit b);
    return b ? n : (n / 10) * 16 + n % 10;
  endfunction

  function automatic int encHr(int h, bit b, bit h24);
    int h12;
    if (h24) return enc(h, b);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (h >= 12 ? 128 : 0) + enc(h12, b);
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int expField(int f);
    case (f)
      0: return enc(ms, binMode);
      1: return enc(mm, binMode);
      2: return encHr(mh, binMode, hr24);
      3: return enc(mdw, binMode);
      4: return enc(mdm, binMode);
      5: return enc(mmo, binMode);
      6: return enc(my, binMode);
      default: return enc(mc, binMode);
    endcase
  endfunction

  task automatic advanceModel();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdw = (mdw == 7) ? 1 : mdw + 1;
          if (mdm == dim(mmo, my)) begin
            mdm = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin
                my = 0;
                mc = (mc == 99) ? 0 : mc + 1;
              end
            end
          end else mdm++;
        end
      end
    end
  endtask

  // called at a negedge; compares every field with the model
  task automatic expectAll(string tag);
    for (int f = 0; f < 8; f++) begin
      rdSel = 3'(f);
      #1;
      chk(int'(rdData) == expField(f), tag, int'(rdData), expField(f));
    end
  endtask

  task automatic writeField(int sel, int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = 8'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setModel(int s, int m, int h, int dw, int dm, int mo, int y, int c);
    ms = s; mm = m; mh = h; mdw = dw; mdm = dm; mmo = mo; my = y; mc = c;
  endtask

  task automatic loadModel(bit b, bit h24);
    @(negedge clk);
    binMode = b; hr24 = h24; setHold = 1'b1;
    for (int f = 0; f < 8; f++) writeField(f, expField(f));
    @(negedge clk);
    setHold = 1'b0;
  endtask

  task automatic stepTick(string tag);
    int nb;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    nb = 0;
    while (updBusy && nb < 50) begin
      nb++;
      @(negedge clk);
    end
    chk(nb == LEAD, "R11", nb, LEAD);
    chk(updDone == 1'b1, "R11", int'(updDone), 1);
    advanceModel();
    expectAll(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    setModel(0, 0, 0, 1, 1, 1, 0, 0);
    expectAll("R1");
    chk(updBusy == 1'b0, "R1", int'(updBusy), 0);
    chk(updDone == 1'b0, "R1", int'(updDone), 0);

    // R2 raw store and read back
    @(negedge clk); setHold = 1'b1;
    for (int f = 0; f < 8; f++) writeField(f, 8'hA0 + f * 5);
    for (int f = 0; f < 8; f++) begin
      rdSel = 3'(f); #1;
      chk(int'(rdData) == 8'hA0 + f * 5, "R2", int'(rdData), 8'hA0 + f * 5);
    end
    // R4 mode change leaves bytes untouched
    @(negedge clk); binMode = 1'b1; hr24 = 1'b0;
    @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      rdSel = 3'(f); #1;
      chk(int'(rdData) == 8'hA0 + f * 5, "R4", int'(rdData), 8'hA0 + f * 5);
    end
    // R3 writes without hold ignored
    @(negedge clk); setHold = 1'b0;
    for (int f = 0; f < 8; f++) writeField(f, 8'h11);
    for (int f = 0; f < 8; f++) begin
      rdSel = 3'(f); #1;
      chk(int'(rdData) == 8'hA0 + f * 5, "R3", int'(rdData), 8'hA0 + f * 5);
    end

    // R5 running sequence across minute, hour and day (R8 dow 7 -> 1)
    for (int b = 0; b < 2; b++) begin
      setModel(30, 58, 23, 7, 28, 2, 23, 20);
      loadModel(b[0], b[0]);
      for (int k = 0; k < 100; k++) stepTick("R5");
    end

    // R6 / R7 every hour, both formats, both encodings
    for (int b = 0; b < 2; b++)
      for (int f24 = 0; f24 < 2; f24++)
        for (int h = 0; h < 24; h++) begin
          setModel(59, 59, h, 3, 10, 5, 40, 20);
          loadModel(b[0], f24[0]);
          stepTick(f24 != 0 ? "R6" : "R7");
        end

    // R9 last day of every month, leap and non-leap year; R8 day of week
    for (int b = 0; b < 2; b++)
      for (int yi = 0; yi < 2; yi++)
        for (int mo = 1; mo <= 12; mo++) begin
          setModel(59, 59, 23, mo % 7 + 1, dim(mo, 23 + yi), mo, 23 + yi, 20);
          loadModel(b[0], 1'b1);
          stepTick("R9");
        end
    // R9 day before the end stays in the month
    setModel(59, 59, 23, 2, 28, 2, 24, 20);
    loadModel(1'b0, 1'b1);
    stepTick("R9");

    // R10 year and century wrap
    for (int b = 0; b < 2; b++) begin
      setModel(59, 59, 23, 5, 31, 12, 99, 19);
      loadModel(b[0], 1'b0);
      stepTick("R10");
      setModel(59, 59, 23, 5, 31, 12, 99, 99);
      loadModel(b[0], 1'b1);
      stepTick("R10");
    end

    // R12 tick during hold does nothing
    setModel(10, 20, 5, 2, 3, 4, 5, 20);
    loadModel(1'b0, 1'b1);
    @(negedge clk); setHold = 1'b1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int k = 0; k < LEAD + 2; k++) begin
      chk(updBusy == 1'b0 && updDone == 1'b0, "R12", int'({updBusy, updDone}), 0);
      @(negedge clk);
    end
    expectAll("R12");
    setHold = 1'b0;

    // R12 hold raised in the last busy cycle drops the advance
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (LEAD - 1) @(negedge clk);
    chk(updBusy == 1'b1, "R12", int'(updBusy), 1);
    setHold = 1'b1;
    @(negedge clk);
    chk(updDone == 1'b0, "R12", int'(updDone), 0);
    expectAll("R12");
    @(negedge clk); setHold = 1'b0;
    chk(updDone == 1'b0, "R12", int'(updDone), 0);

    // normal advance still works afterwards
    stepTick("R11");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule